// File: doc/BRIEF.md
# Fine Phase-Shift Port Model

This block is a synthesizable behavioural model of the dynamic fine phase-shift port of a clock manager. It runs entirely on the phase-shift clock. A caller raises a one-cycle request strobe together with a direction bit. The block then works through a fixed acknowledge latency and answers with a one-cycle acknowledge pulse. In the same cycle as that pulse, it moves the phase position of every output that is configured for fine shifting by one step. One step equals one fifty-sixth of the VCO period, which is about 14.29 ps when the VCO runs at 1250 MHz.

The model keeps one phase-position counter for each clock output. Each counter counts fine steps and lives in the range 0 to modulus-1. The modulus of an output is 56 times that output's VCO divide value, so one full output period can always be reached. Moving past either end wraps round to the other end.

A shift is an absolute time delay. For that reason every fine-enabled output moves by the same number of steps, whatever its divide value. Outputs that are not fine-enabled stay at position zero. The model reports every position and a busy flag, so logic that drives a real clock manager's phase port can be exercised without generating real clocks.

Top module: `fine_phase_shifter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `step_pos` is all zeros and both `busy` and `shift_done` are low.
- R2: A request is accepted when `shift_en` is sampled high while `busy` is low. `shift_done` is then high in exactly the 12th cycle after the cycle in which `shift_en` was high, and it stays high for that one cycle only.
- R3: `busy` is high from the cycle after an accepted request up to the cycle before `shift_done`. It is low in the cycle in which `shift_done` is high.
- R4: A `shift_en` pulse that arrives while `busy` is high is ignored. The pending request keeps its own timing and direction, and no second `shift_done` follows.
- R5: With `shift_up`=1 sampled together with an accepted request, every fine-enabled output's position goes up by one. The new value is visible in the same cycle as `shift_done`, and at no other time does any position change.
- R6: With `shift_up`=0, every fine-enabled output's position goes down by one, and a position of 0 becomes modulus-1.
- R7: The modulus of output i is 56*div_i. An increment from modulus-1 gives 0. With the default divides 8, 2 and 4 the moduli are 448, 112 and 224.
- R8: An output whose bit in `FINE_EN` is 0 stays at position 0 for ever. By default output 2 is not enabled.
- R9: All fine-enabled outputs move by the same step count on every shift, even when their divides differ.
- R10: Raising `rst` during a pending shift clears every position and `busy`, and no `shift_done` follows for the cancelled request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-shift clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | One-cycle request strobe |
| shift_up | input | 1 | Direction sampled with the request: 1 increments, 0 decrements |
| shift_done | output | 1 | One-cycle acknowledge pulse, 12 cycles after the request |
| busy | output | 1 | A shift is pending |
| step_pos | output | NUM_OUT*POS_W | Position of output i in bits [i*POS_W +: POS_W] (POS_W=9 by default) |

## Verification
If the request strobe is high in cycle c, `busy` is due in cycle c+1, and both `shift_done` and the new positions are due in cycle c+12. The acknowledge pulse must be gone again in cycle c+13. The bench drives every input on the falling edge. It then counts rising edges from the edge that samples the strobe and reads the outputs on the falling edge inside each of those cycles. This lets it check that `shift_done` is low in c+11, high in c+12 and low in c+13. A complete sweep of 448 increments and a run of decrements are each compared, step by step, with positions that the bench works out modulo 448 and modulo 112.

// File: rtl/fps_pkg.sv
package fps_pkg;

    // Fine steps in one VCO period
    localparam int STEPS_PER_VCO = 56;
    // Upper bound on outputs supported by the helper functions
    localparam int MAX_OUTS      = 16;
    localparam int DIV_W         = 8;
    localparam int CALC_W        = 16;

    typedef struct packed {
        logic fire;   // apply one step this edge
        logic up;     // direction of that step
    } step_cmd_t;

    typedef enum logic [1:0] {
        TMR_IDLE    = 2'b00,
        TMR_WAIT    = 2'b01,
        TMR_FINAL   = 2'b10
    } tmr_state_t;

    // Largest divide value in a packed list of NUM entries
    function automatic int max_div(input logic [MAX_OUTS*DIV_W-1:0] divs, input int num);
        int best;
        best = 1;
        for (int i = 0; i < MAX_OUTS; i++) begin
            if (i < num && int'(divs[i*DIV_W +: DIV_W]) > best)
                best = int'(divs[i*DIV_W +: DIV_W]);
        end
        return best;
    endfunction

    // One step of a modulo counter in either direction
    function automatic logic [CALC_W-1:0] wrap_step(
        input logic [CALC_W-1:0] pos,
        input logic              up,
        input logic [CALC_W-1:0] modulus
    );
        logic [CALC_W-1:0] nxt;
        if (up) begin
            nxt = (pos == modulus - 1'b1) ? '0 : pos + 1'b1;
        end else begin
            nxt = (pos == '0) ? modulus - 1'b1 : pos - 1'b1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/fps_ack_timer.sv
module fps_ack_timer
    import fps_pkg::*;
#(
    parameter int LATENCY = 12
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  logic      req_up,
    output logic      busy,
    output logic      done,
    output step_cmd_t cmd
);

    localparam int CNT_W = $clog2(LATENCY + 1);

    tmr_state_t       state;
    logic [CNT_W-1:0] remain;
    logic             dir_q;
    logic             accept;
    logic             last;

    assign accept = req && (state == TMR_IDLE);
    assign last   = (state == TMR_FINAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TMR_IDLE;
            remain <= '0;
            dir_q  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                TMR_IDLE: begin
                    if (accept) begin
                        dir_q  <= req_up;
                        remain <= CNT_W'(LATENCY - 2);
                        state  <= (LATENCY == 2) ? TMR_FINAL : TMR_WAIT;
                    end
                end
                TMR_WAIT: begin
                    remain <= remain - 1'b1;
                    if (remain == CNT_W'(1))
                        state <= TMR_FINAL;
                end
                TMR_FINAL: begin
                    done  <= 1'b1;
                    state <= TMR_IDLE;
                end
                default: state <= TMR_IDLE;
            endcase
        end
    end

    assign busy     = (state != TMR_IDLE);
    assign cmd.fire = last;
    assign cmd.up   = dir_q;

endmodule

// File: rtl/fps_phase_slot.sv
module fps_phase_slot
    import fps_pkg::*;
#(
    parameter int MODULUS = 448,
    parameter bit FINE    = 1'b1,
    parameter int POS_W   = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  step_cmd_t        cmd,
    output logic [POS_W-1:0] pos
);

    generate
        if (FINE) begin : g_fine
            logic [POS_W-1:0] pos_q;
            logic [POS_W-1:0] pos_nxt;

            assign pos_nxt = POS_W'(wrap_step(CALC_W'(pos_q), cmd.up, CALC_W'(MODULUS)));

            always_ff @(posedge clk) begin
                if (rst)
                    pos_q <= '0;
                else if (cmd.fire)
                    pos_q <= pos_nxt;
            end
            assign pos = pos_q;
        end else begin : g_fixed
            assign pos = '0;
        end
    endgenerate

endmodule

// File: rtl/fine_phase_shifter.sv
module fine_phase_shifter #(
    parameter int                        NUM_OUT = 3,
    parameter logic [NUM_OUT*8-1:0]      OUT_DIV = {8'd4, 8'd2, 8'd8},
    parameter logic [NUM_OUT-1:0]        FINE_EN = 3'b011,
    parameter int                        LATENCY = 12,
    parameter int                        POS_W   = $clog2(fps_pkg::STEPS_PER_VCO *
                                               fps_pkg::max_div(
                                                   (fps_pkg::MAX_OUTS*fps_pkg::DIV_W)'(OUT_DIV),
                                                   NUM_OUT))
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     shift_en,
    input  logic                     shift_up,
    output logic                     shift_done,
    output logic                     busy,
    output logic [NUM_OUT*POS_W-1:0] step_pos
);

    import fps_pkg::*;

    step_cmd_t cmd;

    fps_ack_timer #(
        .LATENCY (LATENCY)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .req    (shift_en),
        .req_up (shift_up),
        .busy   (busy),
        .done   (shift_done),
        .cmd    (cmd)
    );

    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
            localparam int MOD_I = STEPS_PER_VCO * int'(OUT_DIV[i*8 +: 8]);
            fps_phase_slot #(
                .MODULUS (MOD_I),
                .FINE    (FINE_EN[i]),
                .POS_W   (POS_W)
            ) u_slot (
                .clk (clk),
                .rst (rst),
                .cmd (cmd),
                .pos (step_pos[i*POS_W +: POS_W])
            );
        end
    endgenerate

endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
    parameter int                 NUM_OUT = 3,
    parameter int                 POS_W   = 9,
    parameter logic [NUM_OUT-1:0] FINE_EN = 3'b011,
    parameter int                 LATENCY = 12
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     shift_en,
    input logic                     shift_up,
    input logic                     shift_done,
    input logic                     busy,
    input logic [NUM_OUT*POS_W-1:0] step_pos
);

    localparam int AGE_W = $clog2(LATENCY + 2);

    logic             track;
    logic [AGE_W-1:0] age;

    always_ff @(posedge clk) begin
        if (rst) begin
            track <= 1'b0;
            age   <= '0;
        end else if (shift_en && !busy) begin
            track <= 1'b1;
            age   <= AGE_W'(1);
        end else if (shift_done) begin
            track <= 1'b0;
            age   <= '0;
        end else if (track) begin
            age <= age + 1'b1;
        end
    end

    // R2
    done_latency_chk: assert property (@(posedge clk) disable iff (rst)
        shift_done |-> (track && age == AGE_W'(LATENCY)));

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        shift_done |=> !shift_done);

    // R3
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !busy) |=> busy);

    // R3
    busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        shift_done |-> !busy);

    // R5
    pos_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_done && !$past(rst)) |-> $stable(step_pos));

    generate
        for (genvar i = 0; i < NUM_OUT; i++) begin : g_off
            if (!FINE_EN[i]) begin : g_chk
                // R8
                fixed_zero_chk: assert property (@(posedge clk) disable iff (rst)
                    step_pos[i*POS_W +: POS_W] == '0);
            end
        end
    endgenerate

endmodule

bind fine_phase_shifter fps_checker #(
    .NUM_OUT (NUM_OUT),
    .POS_W   (POS_W),
    .FINE_EN (FINE_EN),
    .LATENCY (LATENCY)
) u_fps_chk (
    .clk        (clk),
    .rst        (rst),
    .shift_en   (shift_en),
    .shift_up   (shift_up),
    .shift_done (shift_done),
    .busy       (busy),
    .step_pos   (step_pos)
);

// File: tb/fine_phase_shifter_tb.sv
`timescale 1ns / 1ps
module fine_phase_shifter_tb;

    localparam int PW   = 9;
    localparam int MOD0 = 448;
    localparam int MOD1 = 112;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          shift_en = 1'b0;
    logic          shift_up = 1'b0;
    logic          shift_done;
    logic          busy;
    logic [3*PW-1:0] step_pos;

    int checks   = 0;
    int failures = 0;
    int exp0     = 0;
    int exp1     = 0;

    fine_phase_shifter u_dut (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (shift_en),
        .shift_up   (shift_up),
        .shift_done (shift_done),
        .busy       (busy),
        .step_pos   (step_pos)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pos(input int i);
        return int'(step_pos[i*PW +: PW]);
    endfunction

    task automatic chk_pos(input string tag);
        chk({tag, " R7 R9 out0"}, pos(0), exp0);
        chk({tag, " R7 R9 out1"}, pos(1), exp1);
        chk("R8 out2 fixed", pos(2), 0);
    endtask

    // Full request with timing checks; positions checked on the done cycle
    task automatic do_shift(input logic up, input bit full);
        @(negedge clk);
        shift_en = 1'b1;
        shift_up = up;
        @(posedge clk);
        @(negedge clk);
        shift_en = 1'b0;
        shift_up = ~up;
        if (full) chk("R3 busy after request", busy, 1);
        repeat (10) @(posedge clk);
        @(negedge clk);
        if (full) begin
            chk("R2 no done at c+11", shift_done, 0);
            chk("R3 busy at c+11", busy, 1);
            chk_pos("R5 R6 hold before done");
        end
        @(posedge clk);
        @(negedge clk);
        if (up) begin
            exp0 = (exp0 + 1) % MOD0;
            exp1 = (exp1 + 1) % MOD1;
        end else begin
            exp0 = (exp0 + MOD0 - 1) % MOD0;
            exp1 = (exp1 + MOD1 - 1) % MOD1;
        end
        chk("R2 done at c+12", shift_done, 1);
        chk("R3 busy low with done", busy, 0);
        chk_pos(up ? "R5 step up" : "R6 step down");
        @(posedge clk);
        @(negedge clk);
        if (full) chk("R2 done one cycle", shift_done, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 done in reset", shift_done, 0);
        chk("R1 pos in reset", int'(step_pos), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 pos after reset", int'(step_pos), 0);

        // Full sweep upward: out0 wraps once, out1 wraps four times
        for (int n = 0; n < MOD0; n++) begin
            do_shift(1'b1, n < 3 || n > MOD0 - 3 || n == MOD1 - 1);
            if (n == MOD1 - 1) chk("R7 out1 wrapped to 0", pos(1), 0);
        end
        chk("R7 out0 full period", pos(0), 0);

        // Downward across zero
        for (int n = 0; n < 3; n++) do_shift(1'b0, 1'b1);
        chk("R6 out0 below zero", pos(0), MOD0 - 3);
        chk("R6 out1 below zero", pos(1), MOD1 - 3);

        // R4: second strobe while busy is ignored
        @(negedge clk);
        shift_en = 1'b1;
        shift_up = 1'b1;
        @(posedge clk);
        @(negedge clk);
        shift_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        shift_en = 1'b1;
        shift_up = 1'b0;
        @(posedge clk);
        @(negedge clk);
        shift_en = 1'b0;
        chk("R4 no early done", shift_done, 0);
        repeat (7) @(posedge clk);
        @(negedge clk);
        chk("R4 original timing", shift_done, 1);
        exp0 = (exp0 + 1) % MOD0;
        exp1 = (exp1 + 1) % MOD1;
        chk_pos("R4 original direction");
        for (int k = 0; k < 16; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R4 no second done", shift_done, 0);
        end
        chk_pos("R4 positions unchanged");

        // R10: reset mid-shift
        @(negedge clk);
        shift_en = 1'b1;
        shift_up = 1'b1;
        @(posedge clk);
        @(negedge clk);
        shift_en = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp0 = 0;
        exp1 = 0;
        chk("R10 busy cleared", busy, 0);
        chk_pos("R10 cleared");
        for (int k = 0; k < 16; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk("R10 no done after cancel", shift_done, 0);
        end
        chk_pos("R10 still cleared");

        // One more shift after the cancel works normally
        do_shift(1'b0, 1'b1);
        chk("R6 out0 from zero", pos(0), MOD0 - 1);
        chk("R6 out1 from zero", pos(1), MOD1 - 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule